// File: doc/BRIEF.md
# Programmable Multi-Modulus Divide-by-2/3 Chain

This block is the integer section of a fractional-N feedback divider. A row of divide-by-2/3 stages is clocked by the prescaled oscillator clock. The input clock is a synchronous clock that enters the first stage as a tick on every cycle. Each stage divides the tick stream it receives by two. A stage divides by three for one period only when its own control bit is set and the feedback it receives from the next slower stage is asserted. The slowest active stage always has its feedback forced on. The chain therefore closes one output period after 2^m plus the value of the m low control bits input clocks, where m is the number of active stages.

Range-extension logic chooses m from the position of the highest set bit of the control word, with a floor of five stages. Every word from 32 to 1023 then gives a period equal to the word itself. Words below 32 run five stages and give 32 plus the word.

The output marker is a one-clock pulse in the last input cycle of each period. The word is captured in that same cycle. A loop that dithers its ratio can therefore hand over a new value on every output period, and the new value takes effect exactly at the period boundary. The feedback signal of each stage is also brought out.

Top module: `mm_div_chain`

## Requirements
- R1: For a captured word w with 32 <= w <= 1023, the output period is exactly w input clocks. The period is counted from the clock after one fout pulse up to and including the next fout pulse.
- R2: For a captured word w below 32, five stages run, and the period is 32 + w input clocks.
- R3: fout is high for exactly one input clock per period. The next period starts on the following clock, when fout falls.
- R4: The word on ratio_i is captured only in the clock where fout is high, and while reset is asserted. A change on ratio_i at any other time has no effect on the period in progress.
- R5: Reset is synchronous. While it is asserted, fout and every bit of fb_o are low, and the word is loaded continuously. The first period after release uses the word present at release, and the release clock counts as the first clock of that period.
- R6: In the clock where fout is high, fb_o equals a mask with ones in bits 0 to m-1, where m = max(5, index of the highest set bit of the word). Bit i of fb_o is the feedback out of stage i, and stage 0 is the fastest stage. Stages at index m and above keep their feedback low at all times.
- R7: Two fout pulses are never less than 32 input clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Prescaled input clock that the chain divides |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_i | input | 10 | Division control word, captured once per output period |
| fout_o | output | 1 | End-of-period pulse, one input clock wide |
| fb_o | output | 9 | Feedback signal of each stage, bit 0 from the fastest stage |

## Verification
Two events can fall in the same clock: the end-of-period pulse, and the capture of the next control word together with the change of stage count that the word brings. The driver puts the new word on ratio_i during the very clock in which fout is high. It also writes an unrelated value onto ratio_i one clock later, inside the new period. The scoreboard judges each period by its length in input clocks and by the feedback mask seen at its end, both against the word given at the boundary. Corner words cover changes in the stage count from 5 to 9 and back, the values just below and at each power of two, and words below 32.

// File: rtl/mm_div_pkg.sv
package mm_div_pkg;
   // stage counter states of one divide-by-2/3 cell
   typedef enum logic [1:0] {
      PH_FIRST  = 2'd0,
      PH_SECOND = 2'd1,
      PH_EXTRA  = 2'd2
   } cell_phase_t;
endpackage

// File: rtl/div23_cell.sv
module div23_cell
   import mm_div_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic act_i,
   input  logic tick_i,
   input  logic pbit_i,
   input  logic mod_i,
   output logic tick_o,
   output logic mod_o
);
   cell_phase_t ph_q;
   logic        swallow;
   logic        term;

   assign swallow = pbit_i & mod_i;

   always_comb begin
      term = 1'b0;
      if (act_i) begin
         unique case (ph_q)
            PH_SECOND: term = ~swallow;
            PH_EXTRA:  term = 1'b1;
            default:   term = 1'b0;
         endcase
      end
   end

   assign tick_o = tick_i & term;
   assign mod_o  = mod_i & term;

   always_ff @(posedge clk_i) begin
      if (rst_i || !act_i) begin
         ph_q <= PH_FIRST;
      end else if (tick_i) begin
         if (term) begin
            ph_q <= PH_FIRST;
         end else begin
            unique case (ph_q)
               PH_FIRST:  ph_q <= PH_SECOND;
               PH_SECOND: ph_q <= PH_EXTRA;
               default:   ph_q <= PH_FIRST;
            endcase
         end
      end
   end
endmodule

// File: rtl/div_range_ext.sv
module div_range_ext #(
   parameter int CW_W       = 10,
   parameter int MIN_STAGES = 5,
   localparam int NSTG      = CW_W - 1
) (
   input  logic [CW_W-1:0] word_i,
   output logic [NSTG-1:0] act_o,
   output logic [NSTG-1:0] top_o
);
   // highest set bit at or above MIN_STAGES gives the active stage count
   logic [$clog2(CW_W+1)-1:0] nact;

   always_comb begin
      nact = ($clog2(CW_W+1))'(MIN_STAGES);
      for (int b = MIN_STAGES; b < CW_W; b++) begin
         if (word_i[b]) nact = ($clog2(CW_W+1))'(b);
      end
   end

   for (genvar s = 0; s < NSTG; s++) begin : g_sel
      assign act_o[s] = (s < int'(nact));
      assign top_o[s] = (s == int'(nact) - 1);
   end
endmodule

// File: rtl/mm_div_chain.sv
module mm_div_chain #(
   parameter int CW_W       = 10,
   parameter int MIN_STAGES = 5,
   localparam int NSTG      = CW_W - 1
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [CW_W-1:0] ratio_i,
   output logic            fout_o,
   output logic [NSTG-1:0] fb_o
);
   initial begin
      assert (MIN_STAGES >= 2) else $error("MIN_STAGES must be at least 2");
      assert (CW_W >= MIN_STAGES + 1) else $error("CW_W too small for MIN_STAGES");
   end

   logic [CW_W-1:0] word_q;
   logic [NSTG-1:0] act;
   logic [NSTG-1:0] top;
   logic [NSTG:0]   tick;
   logic [NSTG-1:0] mod_dn;
   logic [NSTG-1:0] mod_in;

   // word is retimed at the period boundary so no stage sees it move mid-period
   always_ff @(posedge clk_i) begin
      if (rst_i || fout_o) word_q <= ratio_i;
   end

   div_range_ext #(
      .CW_W       (CW_W),
      .MIN_STAGES (MIN_STAGES)
   ) u_ext (
      .word_i (word_q),
      .act_o  (act),
      .top_o  (top)
   );

   assign tick[0] = 1'b1;

   for (genvar s = 0; s < NSTG; s++) begin : g_stage
      if (s == NSTG - 1) begin : g_last
         assign mod_in[s] = top[s];
      end else begin : g_mid
         assign mod_in[s] = top[s] | mod_dn[s+1];
      end

      div23_cell u_cell (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .act_i  (act[s]),
         .tick_i (tick[s]),
         .pbit_i (word_q[s]),
         .mod_i  (mod_in[s]),
         .tick_o (tick[s+1]),
         .mod_o  (mod_dn[s])
      );
   end

   assign fb_o   = mod_dn;
   assign fout_o = mod_dn[0];
endmodule

// File: rtl/mm_div_chain_chk.sv
module mm_div_chain_chk #(
   parameter int CW_W       = 10,
   parameter int MIN_STAGES = 5,
   localparam int NSTG      = CW_W - 1
) (
   input logic            clk_i,
   input logic            rst_i,
   input logic            fout_o,
   input logic [NSTG-1:0] fb_o,
   input logic [CW_W-1:0] word_q
);
   localparam int GW = CW_W + 1;

   logic [GW-1:0]   gap;
   logic [NSTG-1:0] mask;
   logic [GW-1:0]   expect_len;

   always_comb begin
      int m;
      m = MIN_STAGES;
      for (int b = MIN_STAGES; b < CW_W; b++) if (word_q[b]) m = b;
      mask = '0;
      for (int s = 0; s < NSTG; s++) if (s < m) mask[s] = 1'b1;
      if (word_q < CW_W'(1 << MIN_STAGES))
         expect_len = GW'(1 << MIN_STAGES) + GW'(word_q);
      else
         expect_len = GW'(word_q);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || fout_o) gap <= '0;
      else if (gap != '1) gap <= gap + 1'b1;
   end

   AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (rst_i) fout_o |=> !fout_o); // R3
   AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i) !fout_o |=> $stable(word_q)); // R4
   AST_FB_FULL: assert property (@(posedge clk_i) disable iff (rst_i) fout_o |-> (fb_o == mask)); // R6
   AST_UPPER_IDLE: assert property (@(posedge clk_i) disable iff (rst_i) (fb_o & ~mask) == '0); // R6
   AST_MIN_GAP: assert property (@(posedge clk_i) disable iff (rst_i) fout_o |-> (gap >= GW'((1 << MIN_STAGES) - 1))); // R7
   AST_RATIO: assert property (@(posedge clk_i) disable iff (rst_i) fout_o |-> (gap + 1'b1 == expect_len)); // R1
endmodule

bind mm_div_chain mm_div_chain_chk #(
   .CW_W       (CW_W),
   .MIN_STAGES (MIN_STAGES)
) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .fout_o (fout_o),
   .fb_o   (fb_o),
   .word_q (word_q)
);

// File: tb/tb_mm_div_chain.sv
`timescale 1ns/1ps
module tb_mm_div_chain;
   localparam int CW_W = 10;
   localparam int NSTG = CW_W - 1;
   localparam int NV   = 160;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [CW_W-1:0] ratio = '0;
   logic            fout;
   logic [NSTG-1:0] fb;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   typedef struct { int len; int mask; int word; } exp_t;
   exp_t q[$];

   always #2.5 clk = ~clk;

   mm_div_chain dut (
      .clk_i   (clk),
      .rst_i   (rst),
      .ratio_i (ratio),
      .fout_o  (fout),
      .fb_o    (fb)
   );

   function automatic exp_t model(int w);
      exp_t e;
      int m;
      m = 5;
      for (int b = 5; b < CW_W; b++) if (((w >> b) & 1) != 0) m = b;
      e.len  = (w < 32) ? 32 + w : w;   // R1 R2
      e.mask = (1 << m) - 1;            // R6
      e.word = w;
      return e;
   endfunction

   function automatic int pick(int i);
      int corner[16] = '{100, 0, 31, 32, 33, 63, 64, 1023, 40, 512, 511, 5, 1000, 127, 128, 256};
      if (i < 16) return corner[i];
      return 32 + ($urandom % 700);
   endfunction

   task automatic push_word(int w);
      ratio = CW_W'(w);
      q.push_back(model(w));
   endtask

   // driver
   initial begin
      push_word(pick(0));
      repeat (4) @(posedge clk);
      #1;
      // R5: reset state
      n_chk++;
      if (fout !== 1'b0 || fb !== '0) begin
         n_bad++;
         $display("FAIL R5 reset outputs fout=%b fb=%b expected 0/0", fout, fb);
      end
      @(posedge clk); #1 rst = 1'b0;
      for (int i = 1; i < NV; i++) begin
         do @(negedge clk); while (fout !== 1'b1);
         push_word(pick(i));
         @(negedge clk);
         ratio = CW_W'($urandom);    // R4: mid-period change must be ignored
      end
      do @(negedge clk); while (fout !== 1'b1);
      ratio = '0;
      wait (q.size() == 0);
      @(negedge clk);
      done = 1'b1;
   end

   // monitor / scoreboard
   initial begin
      int cnt;
      exp_t e;
      bit first;
      cnt = 0;
      first = 1'b1;
      forever begin
         @(negedge clk);
         if (!rst) begin
            cnt++;
            if (fout === 1'b1) begin
               if (q.size() == 0) begin
                  n_chk++; n_bad++;
                  $display("FAIL R3 unexpected fout pulse, count=%0d expected none", cnt);
               end else begin
                  e = q.pop_front();
                  n_chk++;
                  if (cnt != e.len) begin
                     n_bad++;
                     if (first)
                        $display("FAIL R5 first period word=%0d len=%0d expected %0d", e.word, cnt, e.len);
                     else if (e.word < 32)
                        $display("FAIL R2 word=%0d len=%0d expected %0d", e.word, cnt, e.len);
                     else
                        $display("FAIL R1 R3 R4 word=%0d len=%0d expected %0d", e.word, cnt, e.len);
                  end
                  n_chk++;
                  if (int'(fb) != e.mask) begin
                     n_bad++;
                     $display("FAIL R6 word=%0d fb=%0h expected %0h", e.word, fb, e.mask);
                  end
                  if (cnt < 32 && cnt != e.len) begin
                     $display("FAIL R7 gap=%0d expected >=32", cnt);
                  end
               end
               cnt = 0;
               first = 1'b0;
            end
         end
      end
   end

   // watchdog and summary
   initial begin
      while (!done && cyc < 190000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog expired after %0d clocks, expected completion", cyc);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule